// File: doc/BRIEF.md
# I2C Command-List Master Sequencer

This block is the control half of an I2C master. Software first loads a small file of 16-bit command words. It then fills a transmit FIFO with the bytes to send and sets a start strobe. The sequencer walks the command slots from slot 0 upward. Each word opens a (repeated) start condition, writes N bytes, reads N bytes or closes with a stop. The sequencer hands each of these to a bit-level timing engine through a request/done handshake. The SCL/SDA waveforms themselves are produced by the engine, outside this block.

During a write, each byte comes from the head of the transmit FIFO. Optionally, the acknowledge the target returns is compared with an expected level. During a read, each byte lands in a receive FIFO, and the master answers with the acknowledge level that the command word selects. A finished slot gets its done bit. A run ends in one of five ways, and each has its own raw flag: completion (a stop), end-of-list (an empty slot or the last slot, with the bus left held), acknowledge mismatch, arbitration loss, or timeout.

Each command word is packed as follows. Bits [7:0] hold the byte count (1..255). Bit 8 enables acknowledge checking. Bit 9 is the expected acknowledge level (1 = NACK expected). Bit 10 is the level the master answers after a read byte (1 = NACK). Bits [15:11] hold the opcode: 6 repeated start, 1 write, 3 read, 2 stop.

Top module: `i2cq_master_seq`

## Requirements
- R1: After `go`, slots run in ascending order from slot 0. Opcodes 6/1/3/2 issue engine operations start (eng_op 0), write byte (2), read byte (3) and stop (1) respectively.
- R2: A write command with count N issues N write-byte requests. Each request carries the transmit FIFO head, and the FIFO pops once per completed byte, so bytes go out in push order.
- R3: A read command with count N issues N read-byte requests. Each request drives command bit 10 on `eng_ack_drive`, and the received bytes are pushed into the receive FIFO in arrival order.
- R4: When bit 8 is set and `eng_ack_rx` differs from bit 9 at a write byte's completion, `st_nack` rises, `busy` falls, no further request is issued and that slot's done bit stays clear. When bit 8 is clear, the acknowledge is ignored.
- R5: `cmd_done[i]` is set when slot i finishes. All done bits clear on an accepted `go` or on `cmd_clr`, and `cmd_clr` also zeroes every slot word.
- R6: Completing a stop command raises `st_complete` and drops `busy`.
- R7: A word whose opcode is none of the four (including an all-zero word), or finishing slot 15, raises `st_end` and drops `busy` without issuing a stop.
- R8: `eng_arb_lost` at a completion raises `st_arb` and halts the list.
- R9: If `TIMEOUT_CYC` cycles pass in the wait state with no engine completion (including a write stalled on an empty transmit FIFO), `st_timeout` rises and the list halts.
- R10: `go` while `busy` has no effect on the running list.
- R11: Each FIFO holds 32 bytes. `tx_full` asserts at level 32 and a push when full is dropped. `tx_clr` and `rx_clr` empty their FIFO.
- R12: `fsm_clr` returns the sequencer to idle within one cycle and clears all status flags.
- R13: After reset: `busy`, all flags, `eng_req` and `cmd_done` are 0, and both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Write a command slot |
| cmd_idx | input | 4 | Slot index for the write |
| cmd_wdata | input | 16 | Command word |
| cmd_clr | input | 1 | Zero all slots and done bits |
| cmd_done | output | 16 | Per-slot done bits |
| tx_push | input | 1 | Push into transmit FIFO |
| tx_data | input | 8 | Transmit byte |
| tx_clr | input | 1 | Empty transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_level | output | 6 | Transmit FIFO fill level |
| rx_pop | input | 1 | Pop receive FIFO |
| rx_clr | input | 1 | Empty receive FIFO |
| rx_data | output | 8 | Receive FIFO head |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_level | output | 6 | Receive FIFO fill level |
| go | input | 1 | Start strobe |
| fsm_clr | input | 1 | Abort to idle, clear flags |
| busy | output | 1 | List running |
| st_complete | output | 1 | Stop finished |
| st_end | output | 1 | End of list reached |
| st_nack | output | 1 | Acknowledge mismatch |
| st_arb | output | 1 | Arbitration lost |
| st_timeout | output | 1 | Engine timeout |
| eng_req | output | 1 | Request to timing engine |
| eng_op | output | 2 | 0 start, 1 stop, 2 write byte, 3 read byte |
| eng_wdata | output | 8 | Byte to transmit |
| eng_ack_drive | output | 1 | Acknowledge level after a read byte |
| eng_done | input | 1 | One-cycle completion pulse |
| eng_rdata | input | 8 | Received byte, valid with eng_done |
| eng_ack_rx | input | 1 | Acknowledge seen after a write byte |
| eng_arb_lost | input | 1 | Arbitration lost, valid with eng_done |

## Verification
The assertions assume a well-behaved engine. It accepts a request only when `eng_req` is high and no earlier operation is pending. It returns exactly one single-cycle `eng_done` per accepted request. It never pulses done on the cycle of acceptance. The bench's engine model follows this rule: it holds off acceptance on the cycle it reports done, and a flush returns it to idle between tests. The stimulus keeps byte counts within 1..255, keeps queued bytes within FIFO depth, and never issues `fsm_clr` together with `go`.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
    localparam logic [4:0] OP_RSTART = 5'd6;
    localparam logic [4:0] OP_WRITE  = 5'd1;
    localparam logic [4:0] OP_READ   = 5'd3;
    localparam logic [4:0] OP_STOP   = 5'd2;

    typedef struct packed {
        logic [4:0] op;
        logic       ack_rsp;
        logic       ack_exp;
        logic       ack_chk;
        logic [7:0] cnt;
    } cmd_word_t;

    typedef enum logic [1:0] {
        EOP_START = 2'd0,
        EOP_STOP  = 2'd1,
        EOP_WR    = 2'd2,
        EOP_RD    = 2'd3
    } eng_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic complete;
        logic endd;
        logic nack;
        logic arb;
        logic tmo;
    } seq_flags_t;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [W-1:0]      wdata,
    input  logic              pop,
    output logic [W-1:0]      rdata,
    output logic [$clog2(DEPTH):0] level,
    output logic              full,
    output logic              empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_regs_t;

    fifo_regs_t     r_q, r_d;
    logic [W-1:0]   mem_q [DEPTH];
    logic           do_push, do_pop;

    assign full  = (r_q.cnt == (AW+1)'(DEPTH));
    assign empty = (r_q.cnt == '0);
    assign level = r_q.cnt;
    assign rdata = mem_q[r_q.rp];

    always_comb begin
        r_d     = r_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) r_d.wp = r_q.wp + 1'b1;
        if (do_pop)  r_d.rp = r_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
        if (clr) r_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem_q[r_q.wp] <= wdata;
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (level == $past(level)));
    assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (AW+1)'(DEPTH));
    assert_clr_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
endmodule

// File: rtl/i2cq_slots.sv
module i2cq_slots #(
    parameter int SLOTS = 16,
    parameter int CW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     we,
    input  logic [$clog2(SLOTS)-1:0] widx,
    input  logic [CW-1:0]            wdata,
    input  logic [$clog2(SLOTS)-1:0] ridx,
    output logic [CW-1:0]            rdata,
    input  logic                     done_set,
    input  logic                     done_clr,
    output logic [SLOTS-1:0]         done
);
    typedef struct packed {
        logic [SLOTS-1:0][CW-1:0] words;
        logic [SLOTS-1:0]         done;
    } slot_regs_t;

    slot_regs_t r_q, r_d;

    assign rdata = r_q.words[ridx];
    assign done  = r_q.done;

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (we && widx == i[$clog2(SLOTS)-1:0]) begin
                r_d.words[i] = wdata;
                r_d.done[i]  = 1'b0;
            end
            if (done_set && ridx == i[$clog2(SLOTS)-1:0]) r_d.done[i] = 1'b1;
        end
        if (done_clr) r_d.done = '0;
        if (clr)      r_d      = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assert_done_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_set && !clr && !done_clr) |=> done[$past(ridx)]);
    assert_clr_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (done == '0));
endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
    import i2cq_pkg::*;
#(
    parameter int SLOTS       = 16,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  logic                     fsm_clr,
    output logic [$clog2(SLOTS)-1:0] slot_ridx,
    input  logic [15:0]              slot_rdata,
    output logic                     done_set,
    output logic                     done_clr,
    input  logic                     tx_empty,
    output logic                     tx_pop,
    input  logic                     rx_full,
    output logic                     rx_push,
    output logic                     eng_req,
    output eng_op_e                  eng_op,
    output logic                     eng_ack_drive,
    input  logic                     eng_done,
    input  logic                     eng_ack_rx,
    input  logic                     eng_arb_lost,
    output logic                     busy,
    output seq_flags_t               flags
);
    localparam int IW = $clog2(SLOTS);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

    typedef struct packed {
        seq_state_e  state;
        logic [IW-1:0] pc;
        cmd_word_t   cur;
        logic [7:0]  remain;
        logic [TW-1:0] tmo;
        seq_flags_t  flags;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    cmd_word_t word;
    logic      advance;

    assign slot_ridx     = r_q.pc;
    assign busy          = (r_q.state != ST_IDLE);
    assign flags         = r_q.flags;
    assign eng_ack_drive = r_q.cur.ack_rsp;
    assign eng_req       = (r_q.state == ST_WAIT) && !(r_q.cur.op == OP_WRITE && tx_empty);

    always_comb begin
        case (r_q.cur.op)
            OP_RSTART: eng_op = EOP_START;
            OP_WRITE:  eng_op = EOP_WR;
            OP_READ:   eng_op = EOP_RD;
            default:   eng_op = EOP_STOP;
        endcase
    end

    always_comb begin
        r_d      = r_q;
        word     = cmd_word_t'(slot_rdata);
        advance  = 1'b0;
        done_set = 1'b0;
        done_clr = 1'b0;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (go) begin
                    r_d.state = ST_FETCH;
                    r_d.pc    = '0;
                    r_d.flags = '0;
                    done_clr  = 1'b1;
                end
            end
            ST_FETCH: begin
                r_d.cur    = word;
                r_d.remain = word.cnt;
                r_d.tmo    = '0;
                if (word.op == OP_RSTART || word.op == OP_WRITE ||
                    word.op == OP_READ   || word.op == OP_STOP) begin
                    r_d.state = ST_WAIT;
                end else begin
                    r_d.flags.endd = 1'b1;
                    r_d.state      = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (eng_done) begin
                    r_d.tmo = '0;
                    if (eng_arb_lost) begin
                        r_d.flags.arb = 1'b1;
                        r_d.state     = ST_IDLE;
                    end else begin
                        case (r_q.cur.op)
                            OP_WRITE: begin
                                tx_pop = 1'b1;
                                if (r_q.cur.ack_chk && (eng_ack_rx != r_q.cur.ack_exp)) begin
                                    r_d.flags.nack = 1'b1;
                                    r_d.state      = ST_IDLE;
                                end else if (r_q.remain == 8'd1) begin
                                    advance = 1'b1;
                                end else begin
                                    r_d.remain = r_q.remain - 8'd1;
                                end
                            end
                            OP_READ: begin
                                rx_push = !rx_full;
                                if (r_q.remain == 8'd1) advance = 1'b1;
                                else                    r_d.remain = r_q.remain - 8'd1;
                            end
                            OP_STOP: begin
                                done_set           = 1'b1;
                                r_d.flags.complete = 1'b1;
                                r_d.state          = ST_IDLE;
                            end
                            default: advance = 1'b1;
                        endcase
                    end
                end else if (r_q.tmo == TW'(TIMEOUT_CYC - 1)) begin
                    r_d.flags.tmo = 1'b1;
                    r_d.state     = ST_IDLE;
                end else begin
                    r_d.tmo = r_q.tmo + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (advance) begin
            done_set = 1'b1;
            if (r_q.pc == LAST) begin
                r_d.flags.endd = 1'b1;
                r_d.state      = ST_IDLE;
            end else begin
                r_d.pc    = r_q.pc + 1'b1;
                r_d.state = ST_FETCH;
            end
        end
        if (fsm_clr) begin
            r_d      = '0;
            done_set = 1'b0;
            done_clr = 1'b0;
            tx_pop   = 1'b0;
            rx_push  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R2: the engine only completes a write byte that was offered from a non-empty FIFO
    assert_pop_has_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
    assert_nack_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.nack) |-> !busy);
    assert_stop_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.complete) |-> !busy);
    assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags) <= 1);
    assert_arb_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.arb) |-> !busy);
    assert_tmo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.tmo < TW'(TIMEOUT_CYC));
    assert_go_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && go && !fsm_clr && !eng_done && r_q.tmo != TW'(TIMEOUT_CYC - 1))
        |=> (r_q.state == ST_WAIT && r_q.pc == $past(r_q.pc)));
    assert_fsm_clr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_clr |=> (!busy && flags == '0));
endmodule

// File: rtl/i2cq_master_seq.sv
module i2cq_master_seq
    import i2cq_pkg::*;
#(
    parameter int SLOTS       = 16,
    parameter int FIFO_DEPTH  = 32,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_we,
    input  logic [$clog2(SLOTS)-1:0] cmd_idx,
    input  logic [15:0]              cmd_wdata,
    input  logic                     cmd_clr,
    output logic [SLOTS-1:0]         cmd_done,
    input  logic                     tx_push,
    input  logic [7:0]               tx_data,
    input  logic                     tx_clr,
    output logic                     tx_full,
    output logic [$clog2(FIFO_DEPTH):0] tx_level,
    input  logic                     rx_pop,
    input  logic                     rx_clr,
    output logic [7:0]               rx_data,
    output logic                     rx_empty,
    output logic [$clog2(FIFO_DEPTH):0] rx_level,
    input  logic                     go,
    input  logic                     fsm_clr,
    output logic                     busy,
    output logic                     st_complete,
    output logic                     st_end,
    output logic                     st_nack,
    output logic                     st_arb,
    output logic                     st_timeout,
    output logic                     eng_req,
    output logic [1:0]               eng_op,
    output logic [7:0]               eng_wdata,
    output logic                     eng_ack_drive,
    input  logic                     eng_done,
    input  logic [7:0]               eng_rdata,
    input  logic                     eng_ack_rx,
    input  logic                     eng_arb_lost
);
    localparam int IW = $clog2(SLOTS);

    logic [IW-1:0] slot_ridx;
    logic [15:0]   slot_rdata;
    logic          done_set, done_clr;
    logic          tx_empty, tx_pop, rx_full, rx_push;
    eng_op_e       op_e;
    seq_flags_t    flags;

    assign eng_op      = op_e;
    assign st_complete = flags.complete;
    assign st_end      = flags.endd;
    assign st_nack     = flags.nack;
    assign st_arb      = flags.arb;
    assign st_timeout  = flags.tmo;

    i2cq_slots #(.SLOTS(SLOTS), .CW(16)) u_slots (
        .clk(clk), .rst_n(rst_n), .clr(cmd_clr),
        .we(cmd_we), .widx(cmd_idx), .wdata(cmd_wdata),
        .ridx(slot_ridx), .rdata(slot_rdata),
        .done_set(done_set), .done_clr(done_clr), .done(cmd_done)
    );

    i2cq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .wdata(tx_data), .pop(tx_pop), .rdata(eng_wdata),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    i2cq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .wdata(eng_rdata), .pop(rx_pop), .rdata(rx_data),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    i2cq_seq #(.SLOTS(SLOTS), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .fsm_clr(fsm_clr),
        .slot_ridx(slot_ridx), .slot_rdata(slot_rdata),
        .done_set(done_set), .done_clr(done_clr),
        .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push),
        .eng_req(eng_req), .eng_op(op_e), .eng_ack_drive(eng_ack_drive),
        .eng_done(eng_done), .eng_ack_rx(eng_ack_rx), .eng_arb_lost(eng_arb_lost),
        .busy(busy), .flags(flags)
    );
endmodule

// File: tb/i2cq_master_seq_bench.sv
module i2cq_master_seq_bench;
    localparam int TMO = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        cmd_we = 0, cmd_clr = 0, tx_push = 0, tx_clr = 0;
    logic        rx_pop = 0, rx_clr = 0, go = 0, fsm_clr = 0;
    logic [3:0]  cmd_idx = 0;
    logic [15:0] cmd_wdata = 0;
    logic [7:0]  tx_data = 0;
    logic [15:0] cmd_done;
    logic        tx_full, rx_empty, busy;
    logic [5:0]  tx_level, rx_level;
    logic [7:0]  rx_data, eng_wdata;
    logic        st_complete, st_end, st_nack, st_arb, st_timeout;
    logic        eng_req, eng_ack_drive;
    logic [1:0]  eng_op;
    logic        eng_done, eng_ack_rx, eng_arb_lost;
    logic [7:0]  eng_rdata;

    i2cq_master_seq #(.TIMEOUT_CYC(TMO)) u_i2cq_master_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .cmd_clr(cmd_clr),
        .cmd_done(cmd_done),
        .tx_push(tx_push), .tx_data(tx_data), .tx_clr(tx_clr), .tx_full(tx_full),
        .tx_level(tx_level),
        .rx_pop(rx_pop), .rx_clr(rx_clr), .rx_data(rx_data), .rx_empty(rx_empty),
        .rx_level(rx_level),
        .go(go), .fsm_clr(fsm_clr), .busy(busy),
        .st_complete(st_complete), .st_end(st_end), .st_nack(st_nack),
        .st_arb(st_arb), .st_timeout(st_timeout),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_ack_drive(eng_ack_drive), .eng_done(eng_done), .eng_rdata(eng_rdata),
        .eng_ack_rx(eng_ack_rx), .eng_arb_lost(eng_arb_lost)
    );

    // ---------------- timing engine model ----------------
    logic       eng_flush = 0, eng_stall = 0;
    int         eng_lat = 3, nack_at = -1, arb_at = -1;
    logic       eng_busy;
    int         eng_cnt, cur_idx, log_n;
    logic [1:0] log_op  [128];
    logic [7:0] log_val [128];
    logic [7:0] log_rd  [128];

    always @(posedge clk) begin
        if (!rst_n || eng_flush) begin
            eng_busy <= 0; eng_done <= 0; eng_cnt <= 0; cur_idx <= 0; log_n <= 0;
            eng_ack_rx <= 0; eng_arb_lost <= 0; eng_rdata <= 0;
        end else if (eng_done) begin
            eng_done <= 0;
        end else if (!eng_busy && eng_req) begin
            eng_busy <= 1; eng_cnt <= eng_lat; cur_idx <= log_n;
            if (log_n < 128) begin
                log_op[log_n]  <= eng_op;
                log_val[log_n] <= (eng_op == 2'd2) ? eng_wdata : {7'd0, eng_ack_drive};
                log_n          <= log_n + 1;
            end
        end else if (eng_busy && !eng_stall) begin
            if (eng_cnt == 0) begin
                eng_done     <= 1; eng_busy <= 0;
                eng_ack_rx   <= (cur_idx == nack_at);
                eng_arb_lost <= (cur_idx == arb_at);
                eng_rdata    <= 8'h3C + 8'(cur_idx * 7);
                log_rd[cur_idx & 127] <= 8'h3C + 8'(cur_idx * 7);
            end else eng_cnt <= eng_cnt - 1;
        end
    end

    // ---------------- checking helpers ----------------
    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected engine activity
    int         nslots, nexp, ntx, txrd;
    logic [1:0] exp_op  [128];
    logic [7:0] exp_val [128];
    logic [7:0] txq     [64];

    function automatic logic [15:0] mk(input logic [4:0] op, input bit ck, input bit ex,
                                       input bit rs, input logic [7:0] n);
        return {op, rs, ex, ck, n};
    endfunction

    task automatic wr_slot(input int i, input logic [15:0] w);
        @(negedge clk); cmd_we = 1; cmd_idx = 4'(i); cmd_wdata = w;
        @(negedge clk); cmd_we = 0;
    endtask

    task automatic add_cmd(input logic [4:0] op, input bit ck, input bit ex, input bit rs,
                           input logic [7:0] n);
        wr_slot(nslots, mk(op, ck, ex, rs, n));
        nslots++;
        case (op)
            5'd6: begin exp_op[nexp] = 2'd0; exp_val[nexp] = 8'd0; nexp++; end
            5'd2: begin exp_op[nexp] = 2'd1; exp_val[nexp] = 8'd0; nexp++; end
            5'd1: for (int k = 0; k < n; k++) begin
                      exp_op[nexp] = 2'd2; exp_val[nexp] = txq[txrd]; txrd++; nexp++;
                  end
            5'd3: for (int k = 0; k < n; k++) begin
                      exp_op[nexp] = 2'd3; exp_val[nexp] = {7'd0, rs}; nexp++;
                  end
            default: ;
        endcase
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk); tx_push = 1; tx_data = b;
        @(negedge clk); tx_push = 0;
        if (ntx < 64) txq[ntx] = b;
        ntx++;
    endtask

    task automatic fresh();
        @(negedge clk); cmd_clr = 1; tx_clr = 1; rx_clr = 1; eng_flush = 1;
        @(negedge clk); cmd_clr = 0; tx_clr = 0; rx_clr = 0; eng_flush = 0;
        nslots = 0; nexp = 0; ntx = 0; txrd = 0; nack_at = -1; arb_at = -1;
        eng_stall = 0; eng_lat = 3;
    endtask

    task automatic pulse_go();
        @(negedge clk); go = 1;
        @(negedge clk); go = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk(!busy, "R9 run terminates", busy, 0);
    endtask

    // ---------------- table-driven transactions ----------------
    typedef struct packed {
        logic [6:0] addr;
        logic [7:0] wlen;
        logic [7:0] rlen;
        logic [7:0] lat;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{7'h50, 8'd2, 8'd0, 8'd1},
        '{7'h2A, 8'd3, 8'd4, 8'd3},
        '{7'h11, 8'd0, 8'd1, 8'd0},
        '{7'h7F, 8'd5, 8'd2, 8'd5},
        '{7'h33, 8'd1, 8'd6, 8'd2}
    };

    initial begin : watchdog
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int mism, rdi, wrs;
        logic [15:0] mask;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(busy == 0, "R13 busy", busy, 0);
        chk({st_complete, st_end, st_nack, st_arb, st_timeout} == 0, "R13 flags",
            {st_complete, st_end, st_nack, st_arb, st_timeout}, 0);
        chk(eng_req == 0 && cmd_done == 0, "R13 req/done", cmd_done, 0);
        chk(tx_level == 0 && rx_empty, "R13 fifos", tx_level, 0);
        rst_n = 1;
        @(negedge clk);

        foreach (VECS[v]) begin
            fresh();
            eng_lat = int'(VECS[v].lat);
            push_tx({VECS[v].addr, 1'b0});
            for (int k = 0; k < VECS[v].wlen; k++) push_tx(8'(VECS[v].addr) ^ 8'(k * 13 + 1));
            if (VECS[v].rlen != 0) push_tx({VECS[v].addr, 1'b1});
            add_cmd(5'd6, 0, 0, 0, 0);
            add_cmd(5'd1, 1, 0, 0, VECS[v].wlen + 8'd1);
            if (VECS[v].rlen != 0) begin
                add_cmd(5'd6, 0, 0, 0, 0);
                add_cmd(5'd1, 1, 0, 0, 8'd1);
                if (VECS[v].rlen > 1) add_cmd(5'd3, 0, 0, 0, VECS[v].rlen - 8'd1);
                add_cmd(5'd3, 0, 0, 1, 8'd1);
            end
            add_cmd(5'd2, 0, 0, 0, 0);
            pulse_go();
            wait_idle();
            chk(st_complete == 1, "R6 complete flag", st_complete, 1);
            chk(log_n == nexp, "R1 op count", log_n, nexp);
            mism = 0; wrs = 0;
            for (int k = 0; k < nexp && k < log_n; k++) begin
                if (log_op[k] != exp_op[k]) mism++;
                if (exp_op[k] == 2'd2) begin
                    wrs++;
                    if (log_val[k] != exp_val[k]) mism++;
                end
                if (exp_op[k] == 2'd3 && log_val[k] != exp_val[k]) mism++;
            end
            chk(mism == 0, "R1 R2 R3 op order, write data, ack drive", mism, 0);
            chk(tx_level == 0, "R2 tx drained", tx_level, 0);
            chk(rx_level == 6'(VECS[v].rlen), "R3 rx level", rx_level, VECS[v].rlen);
            rdi = 0; mism = 0;
            for (int k = 0; k < log_n; k++) begin
                if (log_op[k] == 2'd3) begin
                    if (rx_data != log_rd[k]) mism++;
                    @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0;
                    rdi++;
                end
            end
            chk(mism == 0 && rx_empty, "R3 rx order", mism, 0);
            mask = 16'((32'd1 << nslots) - 1);
            chk(cmd_done == mask, "R5 done bits", cmd_done, mask);
        end

        // R4: ACK mismatch with checking halts
        fresh();
        push_tx(8'hA0); push_tx(8'h01); push_tx(8'h02);
        add_cmd(5'd6, 0, 0, 0, 0);
        add_cmd(5'd1, 1, 0, 0, 8'd3);
        add_cmd(5'd2, 0, 0, 0, 0);
        nack_at = 2;
        pulse_go(); wait_idle();
        chk(st_nack == 1 && st_complete == 0, "R4 nack flag", st_nack, 1);
        chk(log_n == 3, "R4 no more requests", log_n, 3);
        chk(cmd_done == 16'h0001, "R4 slot not done", cmd_done, 1);
        chk(tx_level == 1, "R4 tx remaining", tx_level, 1);

        // R4: checking disabled ignores NACK
        fresh();
        push_tx(8'hA0); push_tx(8'h01); push_tx(8'h02);
        add_cmd(5'd6, 0, 0, 0, 0);
        add_cmd(5'd1, 0, 0, 0, 8'd3);
        add_cmd(5'd2, 0, 0, 0, 0);
        nack_at = 2;
        pulse_go(); wait_idle();
        chk(st_complete == 1 && st_nack == 0, "R4 check disabled", st_nack, 0);
        chk(log_n == 5, "R4 all ops issued", log_n, 5);

        // R4: expected NACK matches
        fresh();
        push_tx(8'hA0);
        add_cmd(5'd6, 0, 0, 0, 0);
        add_cmd(5'd1, 1, 1, 0, 8'd1);
        add_cmd(5'd2, 0, 0, 0, 0);
        nack_at = 1;
        pulse_go(); wait_idle();
        chk(st_complete == 1 && st_nack == 0, "R4 expected nack", st_nack, 0);

        // R7: zero slot ends list, bus held
        fresh();
        push_tx(8'h42);
        add_cmd(5'd6, 0, 0, 0, 0);
        add_cmd(5'd1, 1, 0, 0, 8'd1);
        pulse_go(); wait_idle();
        chk(st_end == 1 && st_complete == 0, "R7 end flag", st_end, 1);
        chk(log_n == 2, "R7 no stop issued", log_n, 2);
        chk(cmd_done == 16'h0003, "R7 done bits", cmd_done, 3);

        // R7: last slot ends list
        fresh();
        for (int k = 0; k < 16; k++) add_cmd(5'd6, 0, 0, 0, 0);
        pulse_go(); wait_idle();
        chk(st_end == 1, "R7 last slot end", st_end, 1);
        chk(log_n == 16, "R7 sixteen starts", log_n, 16);
        chk(cmd_done == 16'hFFFF, "R5 all done", cmd_done, 16'hFFFF);

        // R5: cmd_clr clears done bits and slots
        @(negedge clk); cmd_clr = 1; @(negedge clk); cmd_clr = 0;
        chk(cmd_done == 0, "R5 cmd_clr done", cmd_done, 0);
        @(negedge clk); eng_flush = 1; @(negedge clk); eng_flush = 0;
        pulse_go(); wait_idle();
        chk(st_end == 1 && log_n == 0, "R5 R7 cleared slots", log_n, 0);

        // R8: arbitration lost
        fresh();
        push_tx(8'h10); push_tx(8'h11);
        add_cmd(5'd6, 0, 0, 0, 0);
        add_cmd(5'd1, 1, 0, 0, 8'd2);
        add_cmd(5'd2, 0, 0, 0, 0);
        arb_at = 1;
        pulse_go(); wait_idle();
        chk(st_arb == 1, "R8 arb flag", st_arb, 1);
        chk(log_n == 2 && cmd_done == 16'h0001, "R8 halted", log_n, 2);

        // R9: timeout on empty transmit FIFO
        fresh();
        add_cmd(5'd6, 0, 0, 0, 0);
        add_cmd(5'd1, 1, 0, 0, 8'd1);
        add_cmd(5'd2, 0, 0, 0, 0);
        pulse_go(); wait_idle();
        chk(st_timeout == 1, "R9 timeout flag", st_timeout, 1);
        chk(log_n == 1, "R9 only start", log_n, 1);

        // R10: go while busy ignored
        fresh();
        add_cmd(5'd6, 0, 0, 0, 0);
        add_cmd(5'd2, 0, 0, 0, 0);
        eng_lat = 20;
        pulse_go();
        repeat (6) @(negedge clk);
        chk(busy == 1, "R10 busy mid-run", busy, 1);
        pulse_go();
        wait_idle();
        chk(st_complete == 1 && log_n == 2, "R10 no restart", log_n, 2);

        // R12: fsm_clr aborts
        fresh();
        add_cmd(5'd6, 0, 0, 0, 0);
        add_cmd(5'd2, 0, 0, 0, 0);
        eng_stall = 1;
        pulse_go();
        repeat (5) @(negedge clk);
        fsm_clr = 1; @(negedge clk); fsm_clr = 0;
        chk(busy == 0, "R12 idle after clear", busy, 0);
        chk({st_complete, st_end, st_nack, st_arb, st_timeout} == 0, "R12 flags cleared",
            {st_complete, st_end, st_nack, st_arb, st_timeout}, 0);

        // R11: FIFO depth and clear
        fresh();
        for (int k = 0; k < 33; k++) push_tx(8'(k));
        chk(tx_full == 1, "R11 full", tx_full, 1);
        chk(tx_level == 32, "R11 level capped", tx_level, 32);
        add_cmd(5'd1, 0, 0, 0, 8'd32);
        pulse_go(); wait_idle();
        mism = 0;
        for (int k = 0; k < 32 && k < log_n; k++) if (log_val[k] != 8'(k)) mism++;
        chk(mism == 0 && log_n == 32, "R11 overflow byte dropped", mism, 0);
        push_tx(8'h55);
        @(negedge clk); tx_clr = 1; @(negedge clk); tx_clr = 0;
        chk(tx_level == 0, "R11 tx_clr", tx_level, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule